// File: doc/BRIEF.md
# EPROM Program-and-Verify Sequencer

This block burns a contiguous range of locations in a UV-erasable EPROM from a byte stream. Once a start strobe gives it a first and a last address, it takes one byte per location over a valid/ready stream. It first reads the location back. If the cell already holds the wanted byte, no pulse is spent on it. If the wanted byte needs a bit to go from 0 back to 1, the location is rejected at once, because only an erase can do that.

Otherwise the block drives address and data, waits a setup interval, and issues a fixed-length active-low program pulse on the chip-enable/program pin. After a settle gap it does a verify read with output enable. It repeats this pulse-and-verify loop until the readback matches or the pulse cap is reached. The programming supply request stays raised from the first fetch to the last verify and is dropped for the completion cycle.

Each location produces a one-cycle report with its address, its result and the pulses it took. A failing location sets a sticky error and records its address. A configuration bit chosen at start decides whether the run stops at the first failure or carries on. Timings are in clocks and are derived from a clocks-per-microsecond parameter.

Top module: `prom_burn_seq`

## Requirements
- R1: After reset the block is idle: devCeN and devOeN high, devVppOn, devDataOe, srcReady, busy and done low.
- R2: In idle, startIn captures baseAddr, lastAddr and haltOnFail. Locations are processed at baseAddr, baseAddr+1, ... up to lastAddr, wrapping modulo 2^AW, and one stream byte is consumed per location. startIn has no effect while busy.
- R3: Every location is first read (devCeN and devOeN low for READ_CLKS clocks, data bus released). If the readback equals the byte, the location passes with zero pulses; this includes 0xFF on an erased cell.
- R4: After any read, a byte with a 1 in a bit where the readback shows 0 makes the location fail without a further pulse.
- R5: Each program pulse holds devCeN low with devOeN high for exactly CLK_PER_US*PULSE_US clocks. Data is driven throughout the pulse. The pulse is preceded by SETUP_CLKS clocks with data driven and devCeN high.
- R6: Each pulse is followed by SETTLE_CLKS clocks with devCeN and devOeN high and the data bus released. A verify read of READ_CLKS clocks follows.
- R7: A location gets at most MAX_PULSES pulses. It passes at the first verify that matches, and fails if the verify after pulse MAX_PULSES still mismatches.
- R8: Each finished location gives a one-clock locDone with locOk (1 = pass), locAddr and locPulses (the pulses applied to it).
- R9: A failing location sets errSticky and, if errSticky was clear, stores its address in errAddr. Both hold until the next accepted start clears them.
- R10: With haltOnFail=1 the run ends right after the first failing location. With haltOnFail=0 it goes on to lastAddr.
- R11: done is high for exactly one clock, in the same clock as the last locDone. runOk is high in that clock only if no location of the run failed.
- R12: devVppOn is high from the first fetch to the last verify and low in idle and in the done clock. The bench treats a pulse seen without devVppOn and devDataOe as a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start strobe, taken only in idle |
| baseAddr | input | AW | First location of the range |
| lastAddr | input | AW | Last location of the range |
| haltOnFail | input | 1 | 1 = stop at first failing location |
| srcValid | input | 1 | Stream byte valid |
| srcData | input | DW | Stream byte |
| srcReady | output | 1 | Sequencer accepts a byte |
| devAddr | output | AW | Device address |
| devDataOut | output | DW | Byte driven to the device |
| devDataOe | output | 1 | Drive enable for devDataOut |
| devDataIn | input | DW | Byte read from the device |
| devCeN | output | 1 | Chip enable / program pulse, active low |
| devOeN | output | 1 | Output enable, active low |
| devVppOn | output | 1 | Request for the programming supply level |
| busy | output | 1 | Run in progress |
| locDone | output | 1 | Per-location report strobe |
| locOk | output | 1 | Location passed |
| locAddr | output | AW | Reported location |
| locPulses | output | CW | Pulses applied to the reported location |
| done | output | 1 | Run complete, one clock |
| runOk | output | 1 | No failure in the run, valid with done |
| errSticky | output | 1 | A location has failed |
| errAddr | output | AW | First failing location |

## Verification
The bench builds the block with AW=5, CLK_PER_US=1, PULSE_US=4, SETUP_CLKS=1, SETTLE_CLKS=2, READ_CLKS=2 and the full MAX_PULSES=10. Four-clock pulses keep a location that needs ten or eleven pulses within about a hundred clocks. This puts the exact cap, the cap-plus-one failure and stop-versus-continue runs within reach. The 32-location space lets a range wrap past the top address. The device model gives each cell a hidden pulse count before it takes its byte, and can preload cells with zeros that only an erase could clear.

// File: rtl/prom_burn_pkg.sv
package prom_burn_pkg;

  typedef enum logic [1:0] {
    TSEL_SETUP,
    TSEL_PULSE,
    TSEL_SETTLE,
    TSEL_READ
  } tmr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_EVAL,
    ST_SETUP,
    ST_PULSE,
    ST_SETTLE,
    ST_DONE
  } burn_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     start;
    logic     ldData;
    logic     incAddr;
    logic     ldTimer;
    tmr_sel_e tmrSel;
    logic     capRb;
    logic     clrPulse;
    logic     incPulse;
    logic     locPass;
    logic     locFail;
  } burn_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic tmrZero;
    logic rbMatch;
    logic rbStuck;
    logic pulsesAtMax;
    logic atLast;
  } burn_sts_t;

endpackage

// File: rtl/prom_burn_dp.sv
module prom_burn_dp
  import prom_burn_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_PER_US  = 4,
  parameter int PULSE_US    = 50,
  parameter int MAX_PULSES  = 10,
  parameter int SETUP_CLKS  = 1,
  parameter int SETTLE_CLKS = 2,
  parameter int READ_CLKS   = 2,
  localparam int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  burn_ctl_t     ctl,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] lastAddr,
  input  logic [DW-1:0] srcData,
  input  logic [DW-1:0] devDataIn,
  output burn_sts_t     sts,
  output logic [AW-1:0] addrQ,
  output logic [DW-1:0] dataQ,
  output logic          locDone,
  output logic          locOk,
  output logic [AW-1:0] locAddr,
  output logic [CW-1:0] locPulses,
  output logic          errSticky,
  output logic [AW-1:0] errAddr
);

  localparam int PULSE_CLKS = CLK_PER_US * PULSE_US;
  localparam int LONG_A     = (PULSE_CLKS > SETUP_CLKS) ? PULSE_CLKS : SETUP_CLKS;
  localparam int LONG_B     = (SETTLE_CLKS > READ_CLKS) ? SETTLE_CLKS : READ_CLKS;
  localparam int LONGEST    = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int TW         = $clog2(LONGEST + 1);

  logic [AW-1:0] lastQ;
  logic [DW-1:0] rbQ;
  logic [TW-1:0] timerQ;
  logic [TW-1:0] timerLoad;
  logic [CW-1:0] pulseQ;

  // interval length per timed phase, counted down to zero
  always_comb begin
    unique case (ctl.tmrSel)
      TSEL_SETUP:  timerLoad = TW'(SETUP_CLKS - 1);
      TSEL_PULSE:  timerLoad = TW'(PULSE_CLKS - 1);
      TSEL_SETTLE: timerLoad = TW'(SETTLE_CLKS - 1);
      default:     timerLoad = TW'(READ_CLKS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (ctl.ldTimer) begin
      timerQ <= timerLoad;
    end else if (timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      lastQ <= '0;
    end else if (ctl.start) begin
      addrQ <= baseAddr;
      lastQ <= lastAddr;
    end else if (ctl.incAddr) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      rbQ   <= '0;
    end else begin
      if (ctl.ldData) dataQ <= srcData;
      if (ctl.capRb)  rbQ   <= devDataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseQ <= '0;
    end else if (ctl.clrPulse) begin
      pulseQ <= '0;
    end else if (ctl.incPulse) begin
      pulseQ <= pulseQ + 1'b1;
    end
  end

  // per-location report, one clock after the decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      locDone   <= 1'b0;
      locOk     <= 1'b0;
      locAddr   <= '0;
      locPulses <= '0;
    end else begin
      locDone <= ctl.locPass | ctl.locFail;
      if (ctl.locPass | ctl.locFail) begin
        locOk     <= ctl.locPass;
        locAddr   <= addrQ;
        locPulses <= pulseQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errSticky <= 1'b0;
      errAddr   <= '0;
    end else if (ctl.start) begin
      errSticky <= 1'b0;
      errAddr   <= '0;
    end else if (ctl.locFail && !errSticky) begin
      errSticky <= 1'b1;
      errAddr   <= addrQ;
    end
  end

  assign sts.tmrZero     = (timerQ == '0);
  assign sts.rbMatch     = (rbQ == dataQ);
  assign sts.rbStuck     = |(dataQ & ~rbQ);
  assign sts.pulsesAtMax = (pulseQ == CW'(MAX_PULSES));
  assign sts.atLast      = (addrQ == lastQ);

  // R7: the pulse counter never runs past the cap
  assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ <= CW'(MAX_PULSES));

  // R3: a pass decision is only taken on a matching readback
  assert_pass_on_match_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.locPass |-> (rbQ == dataQ));

  // R9: the error flag stays set until a new start
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !ctl.start) |=> errSticky);

endmodule

// File: rtl/prom_burn_ctrl.sv
module prom_burn_ctrl
  import prom_burn_pkg::*;
#(
  parameter int PULSE_CLKS = 200
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      haltOnFail,
  input  logic      srcValid,
  input  burn_sts_t sts,
  output burn_ctl_t ctl,
  output logic      srcReady,
  output logic      ceLow,
  output logic      oeLow,
  output logic      driveData,
  output logic      vppOn,
  output logic      done,
  output logic      busy
);

  burn_state_e stateQ, stateD;
  logic        haltQ;
  logic        finish;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      haltQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (ctl.start) haltQ <= haltOnFail;
    end
  end

  always_comb begin
    ctl       = '0;
    stateD    = stateQ;
    srcReady  = 1'b0;
    ceLow     = 1'b0;
    oeLow     = 1'b0;
    driveData = 1'b0;
    vppOn     = 1'b0;
    done      = 1'b0;
    finish    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startIn) begin
          ctl.start = 1'b1;
          stateD    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        vppOn    = 1'b1;
        srcReady = 1'b1;
        if (srcValid) begin
          ctl.ldData   = 1'b1;
          ctl.clrPulse = 1'b1;
          ctl.ldTimer  = 1'b1;
          ctl.tmrSel   = TSEL_READ;
          stateD       = ST_READ;
        end
      end
      ST_READ: begin
        vppOn = 1'b1;
        ceLow = 1'b1;
        oeLow = 1'b1;
        if (sts.tmrZero) begin
          ctl.capRb = 1'b1;
          stateD    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        vppOn = 1'b1;
        if (sts.rbMatch) begin
          ctl.locPass = 1'b1;
          finish      = 1'b1;
        end else if (sts.rbStuck || sts.pulsesAtMax) begin
          ctl.locFail = 1'b1;
          finish      = 1'b1;
        end else begin
          ctl.ldTimer = 1'b1;
          ctl.tmrSel  = TSEL_SETUP;
          stateD      = ST_SETUP;
        end
        if (finish) begin
          if (sts.atLast || (ctl.locFail && haltQ)) begin
            stateD = ST_DONE;
          end else begin
            ctl.incAddr = 1'b1;
            stateD      = ST_FETCH;
          end
        end
      end
      ST_SETUP: begin
        vppOn     = 1'b1;
        driveData = 1'b1;
        if (sts.tmrZero) begin
          ctl.ldTimer  = 1'b1;
          ctl.tmrSel   = TSEL_PULSE;
          ctl.incPulse = 1'b1;
          stateD       = ST_PULSE;
        end
      end
      ST_PULSE: begin
        vppOn     = 1'b1;
        driveData = 1'b1;
        ceLow     = 1'b1;
        if (sts.tmrZero) begin
          ctl.ldTimer = 1'b1;
          ctl.tmrSel  = TSEL_SETTLE;
          stateD      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        vppOn = 1'b1;
        if (sts.tmrZero) begin
          ctl.ldTimer = 1'b1;
          ctl.tmrSel  = TSEL_READ;
          stateD      = ST_READ;
        end
      end
      default: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

  // pulse-length checker: counts clocks of chip enable low with output enable high
  logic        inPulse;
  logic        chkPrev;
  logic [31:0] chkRun;
  assign inPulse = ceLow && !oeLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkPrev <= 1'b0;
      chkRun  <= '0;
    end else begin
      chkPrev <= inPulse;
      chkRun  <= inPulse ? chkRun + 1 : '0;
    end
  end

  // R5: every program pulse lasts exactly the configured clocks
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chkPrev && !inPulse) |-> (chkRun == 32'(PULSE_CLKS)));

  // R11: completion lasts one clock
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a failure in halt mode ends the run next clock
  assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.locFail && haltQ) |=> (stateQ == ST_DONE));

  // R2: a start while busy leaves the run in progress
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stateQ != ST_DONE) |=> busy);

endmodule

// File: rtl/prom_burn_seq.sv
module prom_burn_seq
  import prom_burn_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_PER_US  = 4,
  parameter int PULSE_US    = 50,
  parameter int MAX_PULSES  = 10,
  parameter int SETUP_CLKS  = 1,
  parameter int SETTLE_CLKS = 2,
  parameter int READ_CLKS   = 2,
  localparam int CW         = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic [AW-1:0] baseAddr,
  input  logic [AW-1:0] lastAddr,
  input  logic          haltOnFail,
  input  logic          srcValid,
  input  logic [DW-1:0] srcData,
  output logic          srcReady,
  output logic [AW-1:0] devAddr,
  output logic [DW-1:0] devDataOut,
  output logic          devDataOe,
  input  logic [DW-1:0] devDataIn,
  output logic          devCeN,
  output logic          devOeN,
  output logic          devVppOn,
  output logic          busy,
  output logic          locDone,
  output logic          locOk,
  output logic [AW-1:0] locAddr,
  output logic [CW-1:0] locPulses,
  output logic          done,
  output logic          runOk,
  output logic          errSticky,
  output logic [AW-1:0] errAddr
);

  burn_ctl_t ctl;
  burn_sts_t sts;
  logic      ceLow, oeLow;

  prom_burn_ctrl #(
    .PULSE_CLKS(CLK_PER_US * PULSE_US)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .haltOnFail(haltOnFail),
    .srcValid  (srcValid),
    .sts       (sts),
    .ctl       (ctl),
    .srcReady  (srcReady),
    .ceLow     (ceLow),
    .oeLow     (oeLow),
    .driveData (devDataOe),
    .vppOn     (devVppOn),
    .done      (done),
    .busy      (busy)
  );

  prom_burn_dp #(
    .AW         (AW),
    .DW         (DW),
    .CLK_PER_US (CLK_PER_US),
    .PULSE_US   (PULSE_US),
    .MAX_PULSES (MAX_PULSES),
    .SETUP_CLKS (SETUP_CLKS),
    .SETTLE_CLKS(SETTLE_CLKS),
    .READ_CLKS  (READ_CLKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .baseAddr (baseAddr),
    .lastAddr (lastAddr),
    .srcData  (srcData),
    .devDataIn(devDataIn),
    .sts      (sts),
    .addrQ    (devAddr),
    .dataQ    (devDataOut),
    .locDone  (locDone),
    .locOk    (locOk),
    .locAddr  (locAddr),
    .locPulses(locPulses),
    .errSticky(errSticky),
    .errAddr  (errAddr)
  );

  assign devCeN = ~ceLow;
  assign devOeN = ~oeLow;
  assign runOk  = done & ~errSticky;

endmodule

// File: tb/prom_burn_seq_bench.sv
module prom_burn_seq_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int AW          = 5;
  localparam int DW          = 8;
  localparam int CPU         = 1;
  localparam int PUS         = 4;
  localparam int MAXP        = 10;
  localparam int SETUPC      = 1;
  localparam int SETTLEC     = 2;
  localparam int READC       = 2;
  localparam int PULSEC      = CPU * PUS;
  localparam int CW          = $clog2(MAXP + 1);
  localparam int NLOC        = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [AW-1:0] baseAddr = '0, lastAddr = '0;
  logic haltOnFail = 1'b0;
  logic srcValid = 1'b0;
  logic [DW-1:0] srcData = '0;
  logic srcReady, devDataOe, devCeN, devOeN, devVppOn, busy;
  logic [AW-1:0] devAddr, locAddr, errAddr;
  logic [DW-1:0] devDataOut, devDataIn;
  logic locDone, locOk, done, runOk, errSticky;
  logic [CW-1:0] locPulses;

  always #(CLK_PERIOD/2) clk = ~clk;

  // device model state
  logic [7:0] mem   [NLOC];
  logic [7:0] initC [NLOC];
  logic [7:0] dataD [NLOC];
  int         needN [NLOC];
  int         gotN  [NLOC];
  logic [7:0] srcBuf[NLOC];

  assign devDataIn = (!devCeN && !devOeN) ? mem[devAddr] : 8'h5A;

  prom_burn_seq #(
    .AW(AW), .DW(DW), .CLK_PER_US(CPU), .PULSE_US(PUS), .MAX_PULSES(MAXP),
    .SETUP_CLKS(SETUPC), .SETTLE_CLKS(SETTLEC), .READ_CLKS(READC)
  ) u_prom_burn_seq (
    .clk(clk), .rstN(rstN), .startIn(startIn), .baseAddr(baseAddr),
    .lastAddr(lastAddr), .haltOnFail(haltOnFail), .srcValid(srcValid),
    .srcData(srcData), .srcReady(srcReady), .devAddr(devAddr),
    .devDataOut(devDataOut), .devDataOe(devDataOe), .devDataIn(devDataIn),
    .devCeN(devCeN), .devOeN(devOeN), .devVppOn(devVppOn), .busy(busy),
    .locDone(locDone), .locOk(locOk), .locAddr(locAddr), .locPulses(locPulses),
    .done(done), .runOk(runOk), .errSticky(errSticky), .errAddr(errAddr)
  );

  int checkCnt = 0;
  int failCnt  = 0;

  // run bookkeeping
  int         srcIdx, srcLen, repIdx, expCount, pulsesObs;
  logic [4:0] runBase;
  bit         expFail, doneSeen;
  logic [4:0] expErrAddr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {pass, pulses} expected for one location
  function automatic logic [4:0] expLoc(input logic [7:0] c, input logic [7:0] d, input int n);
    if (c == d) return {1'b1, 4'd0};
    if ((d & ~c) != 8'h00) return {1'b0, 4'd0};
    if (n <= MAXP) return {1'b1, 4'(n)};
    return {1'b0, 4'(MAXP)};
  endfunction

  task automatic setLoc(input int a, input logic [7:0] c, input logic [7:0] d, input int n);
    initC[a] = c; dataD[a] = d; needN[a] = n; gotN[a] = 0; mem[a] = c;
  endtask

  task automatic monitor();
    int  pLen = 0, rLen = 0, gap = 0;
    bit  afterPulse = 0, prevSetup = 0;
    int  pA = 0;
    logic [7:0] pD = '0;
    logic [4:0] e;
    logic [4:0] ea;
    forever begin
      @(negedge clk);
      if (rstN) begin
        // program pulse
        if (!devCeN && devOeN) begin
          if (pLen == 0) chk(prevSetup, "R5 setup before pulse", 0, 1);
          chk(devVppOn && devDataOe, "R12 pulse with supply and data", 0, 1);
          pLen++; pA = int'(devAddr); pD = devDataOut;
        end else if (pLen != 0) begin
          chk(pLen == PULSEC, "R5 pulse width", pLen, PULSEC);
          gotN[pA]++; pulsesObs++;
          if (gotN[pA] >= needN[pA]) mem[pA] = mem[pA] & pD;
          pLen = 0; afterPulse = 1; gap = 0;
        end
        if (afterPulse && devCeN && devOeN) begin
          if (devDataOe) chk(0, "R6 bus released in settle", 1, 0);
          gap++;
        end
        // read
        if (!devCeN && !devOeN) begin
          if (rLen == 0 && afterPulse) begin
            chk(gap == SETTLEC, "R6 settle gap", gap, SETTLEC);
            afterPulse = 0;
          end
          chk(!devDataOe && devVppOn, "R3 read with bus released", devDataOe, 0);
          rLen++;
        end else if (rLen != 0) begin
          chk(rLen == READC, "R6 read length", rLen, READC);
          rLen = 0;
        end
        prevSetup = devDataOe && devCeN;
        // reports
        if (locDone) begin
          ea = runBase + 5'(repIdx);
          e  = expLoc(initC[ea], dataD[ea], needN[ea]);
          chk(locAddr == ea, "R2 report address", locAddr, ea);
          chk(locOk == e[4], "R8 locOk", locOk, e[4]);
          chk(locPulses == e[3:0], "R7 pulse count", locPulses, e[3:0]);
          chk(pulsesObs == int'(e[3:0]), "R4 pulses seen at device", pulsesObs, e[3:0]);
          pulsesObs = 0;
          repIdx++;
        end
        if (done) begin
          chk(locDone, "R11 done with last report", locDone, 1);
          chk(repIdx == expCount, "R10 reported locations", repIdx, expCount);
          chk(runOk == !expFail, "R11 runOk", runOk, !expFail);
          chk(errSticky == expFail, "R9 errSticky", errSticky, expFail);
          if (expFail) chk(errAddr == expErrAddr, "R9 errAddr", errAddr, expErrAddr);
          chk(!devVppOn, "R12 supply off at done", devVppOn, 0);
          doneSeen = 1;
        end
      end
    end
  endtask

  task automatic feeder();
    forever begin
      @(negedge clk);
      srcValid = (srcIdx < srcLen) && ($urandom % 4 != 0);
      srcData  = srcBuf[srcIdx % NLOC];
    end
  endtask

  task automatic counter();
    forever begin
      @(posedge clk);
      if (srcValid && srcReady) srcIdx++;
    end
  endtask

  task automatic runSeq(input logic [4:0] b, input logic [4:0] l, input bit halt, input bit poke);
    int len;
    logic [4:0] a;
    logic [4:0] e;
    len = int'(5'(l - b)) + 1;
    expCount = len; expFail = 0; expErrAddr = '0;
    for (int k = 0; k < len; k++) begin
      a = b + 5'(k);
      srcBuf[k] = dataD[a];
      e = expLoc(initC[a], dataD[a], needN[a]);
      if (!e[4] && !expFail) begin
        expFail = 1; expErrAddr = a;
        if (halt) begin expCount = k + 1; break; end
      end
    end
    runBase = b; repIdx = 0; srcIdx = 0; srcLen = len; pulsesObs = 0; doneSeen = 0;
    @(negedge clk);
    baseAddr = b; lastAddr = l; haltOnFail = halt; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0; baseAddr = b + 5'd7; lastAddr = b + 5'd9; haltOnFail = !halt;
    chk(busy && devVppOn, "R12 supply raised on start", devVppOn, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      startIn = 1'b1;
      @(negedge clk);
      startIn = 1'b0;
    end
    while (!doneSeen) @(negedge clk);
    @(negedge clk);
    chk(!busy && !devVppOn && devCeN && devOeN, "R12 idle after run", devVppOn, 0);
    for (int k = 0; k < expCount; k++) begin
      a = b + 5'(k);
      e = expLoc(initC[a], dataD[a], needN[a]);
      if (e[4]) chk(mem[a] == dataD[a], "R7 cell content", mem[a], dataD[a]);
    end
    srcLen = 0;
  endtask

  task automatic randFill(input logic [4:0] b, input int len);
    logic [4:0] a;
    logic [7:0] d;
    int r;
    for (int k = 0; k < len; k++) begin
      a = b + 5'(k);
      d = 8'($urandom);
      r = int'($urandom % 8);
      if (r == 0)      setLoc(a, d, d, 1);
      else if (r == 1) setLoc(a, 8'($urandom), d, 1 + int'($urandom % 12));
      else if (r == 2) setLoc(a, 8'hFF, 8'hFF, 1);
      else             setLoc(a, 8'hFF, d, 1 + int'($urandom % 12));
    end
  endtask

  task automatic directedFill();
    setLoc(0, 8'hFF, 8'hFF, 1);   // blank byte on erased cell
    setLoc(1, 8'h3C, 8'h3C, 1);   // already holds the byte
    setLoc(2, 8'hF0, 8'h0F, 1);   // needs erase
    setLoc(3, 8'hFF, 8'hA5, 1);   // one pulse
    setLoc(4, 8'hFF, 8'h00, 10);  // exactly the cap
    setLoc(5, 8'hFF, 8'h12, 11);  // one beyond the cap
    setLoc(6, 8'hFE, 8'hF0, 3);
    setLoc(7, 8'hFF, 8'h81, 2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    srcIdx = 0; srcLen = 0; repIdx = 0; expCount = 0; pulsesObs = 0;
    runBase = '0; expFail = 0; doneSeen = 0; expErrAddr = '0;
    for (int a = 0; a < NLOC; a++) setLoc(a, 8'hFF, 8'hFF, 1);
    fork
      monitor();
      feeder();
      counter();
      begin
        repeat (150000) @(posedge clk);
        failCnt++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(devCeN && devOeN, "R1 enables high", {devCeN, devOeN}, 3);
    chk(!devVppOn && !devDataOe, "R1 supply and bus idle", {devVppOn, devDataOe}, 0);
    chk(!srcReady && !busy && !done, "R1 handshake idle", {srcReady, busy, done}, 0);

    directedFill();
    runSeq(5'd0, 5'd7, 1'b0, 1'b0);     // continue past failures
    directedFill();
    runSeq(5'd0, 5'd7, 1'b1, 1'b0);     // R10 stop at first failure
    directedFill();
    runSeq(5'd3, 5'd4, 1'b0, 1'b1);     // R2 start while busy ignored
    for (int a = 30; a < 32; a++) setLoc(a, 8'hFF, 8'h5A + 8'(a), 2);
    setLoc(0, 8'hFF, 8'h33, 1);
    setLoc(1, 8'h77, 8'h77, 1);
    runSeq(5'd30, 5'd1, 1'b0, 1'b0);    // R2 wrap
    for (int i = 0; i < 6; i++) begin
      logic [4:0] b;
      int len;
      b = 5'($urandom);
      len = 1 + int'($urandom % 16);
      randFill(b, len);
      runSeq(b, b + 5'(len - 1), 1'($urandom), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule